// File: doc/BRIEF.md
# Bus Release and Refresh Arbiter

This block sits inside an external bus controller and decides two things at every qualifying bus-cycle boundary. The first is whether the local master hands the external bus to an outside master. The second is whether a memory refresh runs. An outside master asks for the bus with a level request and receives a level acknowledge. The refresh counter raises a request pulse, and the block answers with a grant that stays high until the refresh cycle reports completion.

The access sequencer supplies an end-of-cycle strobe and a lock level. Lock stays high across any sequence that must not be split, from its first cycle through its last. Such sequences include a wide access split into narrow cycles, a 32-byte line burst, the read and write of a test-and-set, and the two phases of a dual-address DMA transfer. A strobe counts as a boundary only while lock is low. Refresh takes priority over release. While the bus is lent out, a pending refresh reclaims it by dropping the acknowledge early. The block then waits for the outside master to withdraw its request. After the bus returns there is a turnaround of `TURN_CYCLES` cycles before the local side drives the bus again.

Top module: `bus_release_arbiter`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves the block as bus owner: `rel_ack_o`=0, `rfsh_gnt_o`=0 and `local_drive_o`=1, with no refresh pending, so a later boundary without requests changes none of these.
- R2: A release request seen at a boundary (`cyc_end_i`=1, `lock_i`=0) while the block owns the bus and has no refresh pending raises `rel_ack_o` and lowers `local_drive_o` from the next cycle on. Both hold while the request stays high.
- R3: An end-of-cycle strobe that arrives while `lock_i`=1 starts neither a release nor a refresh.
- R4: While the block owns the bus, neither request is acted on in a cycle without an end-of-cycle strobe.
- R5: When the request falls while released, `rel_ack_o` falls in the next cycle. `local_drive_o` stays low for one turnaround cycle and returns high in the cycle after that.
- R6: A one-cycle refresh request pulse is remembered until the next boundary. From the cycle after that boundary, `rfsh_gnt_o` is high until `rfsh_done_i` is seen, and `local_drive_o` stays high throughout. The grant consumes the pending request.
- R7: When refresh and release are both wanted at the same boundary, the refresh is granted first. If the release request is still high when `rfsh_done_i` arrives, `rel_ack_o` rises in the next cycle.
- R8: A refresh request that arrives while the bus is released drops `rel_ack_o` in the next cycle with no grant. The grant follows only after the request has fallen and the turnaround cycle has passed. `rel_ack_o` and `rfsh_gnt_o` are never high together.
- R9: A request raised again during the turnaround is not carried over. It is acknowledged only after a fresh boundary.
- R10: A refresh request arriving while a refresh grant is active stays pending and is granted at the next boundary after the current refresh ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rel_req_i | input | 1 | Outside master asks for the external bus (level) |
| rfsh_req_i | input | 1 | Refresh wanted (pulse or level from refresh counter) |
| cyc_end_i | input | 1 | Last clock of a bus cycle, from the access sequencer |
| lock_i | input | 1 | High across a sequence that must not be split |
| rfsh_done_i | input | 1 | Refresh cycle has completed |
| rel_ack_o | output | 1 | Bus is lent to the outside master |
| rfsh_gnt_o | output | 1 | Refresh cycle may run |
| local_drive_o | output | 1 | Local side may drive the external bus |

## Verification
The assertions assume that the sequencer produces `rfsh_done_i` only while a grant is active. They also assume that the outside master keeps its request high until it has been acknowledged or has withdrawn it. The stimulus raises the done strobe only in cycles where the bench's own expectation says the grant is high. It changes the release request only at points the scenario deliberately probes, namely a drop while released, during reclaim, or during turnaround. Lock is always driven together with or around strobes, never as a free-running random input, so every boundary in the bench is one the scenario intends.

// File: rtl/bra_pkg.sv
package bra_pkg;

  typedef enum logic [2:0] {
    ST_OWN     = 3'd0,
    ST_RFSH    = 3'd1,
    ST_REL     = 3'd2,
    ST_RECLAIM = 3'd3,
    ST_TURN    = 3'd4
  } arb_state_t;

  // A strobe counts only outside a locked sequence.
  function automatic logic is_boundary(input logic cyc_end, input logic lock);
    return cyc_end & ~lock;
  endfunction

  // The local side owns the pads when idle-owning or refreshing.
  function automatic logic local_drives(input arb_state_t s);
    return (s == ST_OWN) || (s == ST_RFSH);
  endfunction

endpackage

// File: rtl/bra_boundary.sv
module bra_boundary (
  input  logic cyc_end_i,
  input  logic lock_i,
  output logic boundary_o
);
  import bra_pkg::*;

  always_comb boundary_o = is_boundary(cyc_end_i, lock_i);

endmodule

// File: rtl/bra_rfsh_pend.sv
module bra_rfsh_pend (
  input  logic clk,
  input  logic rst,
  input  logic rfsh_req_i,
  input  logic grant_start_i,
  output logic want_o
);
  logic pend_q;

  // Pending flag survives until a grant starts; a request in the same
  // cycle as the grant start is served by that grant.
  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= (pend_q | rfsh_req_i) & ~grant_start_i;
  end

  always_comb want_o = pend_q | rfsh_req_i;

endmodule

// File: rtl/bra_turn_timer.sv
module bra_turn_timer #(
  parameter int TURN_CYCLES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic in_turn_i,
  output logic turn_done_o
);
  localparam int CW = (TURN_CYCLES < 2) ? 1 : $clog2(TURN_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TURN_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !in_turn_i) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  always_comb turn_done_o = in_turn_i && (cnt_q == LAST);

endmodule

// File: rtl/bra_fsm.sv
module bra_fsm (
  input  logic clk,
  input  logic rst,
  input  logic boundary_i,
  input  logic rel_req_i,
  input  logic want_rfsh_i,
  input  logic rfsh_done_i,
  input  logic turn_done_i,
  output logic grant_start_o,
  output logic in_turn_o,
  output logic rel_ack_o,
  output logic rfsh_gnt_o,
  output logic local_drive_o
);
  import bra_pkg::*;

  arb_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OWN: begin
        if (boundary_i) begin
          if (want_rfsh_i)    state_d = ST_RFSH;
          else if (rel_req_i) state_d = ST_REL;
        end
      end
      ST_RFSH: begin
        if (rfsh_done_i) state_d = rel_req_i ? ST_REL : ST_OWN;
      end
      ST_REL: begin
        if (!rel_req_i)       state_d = ST_TURN;
        else if (want_rfsh_i) state_d = ST_RECLAIM;
      end
      ST_RECLAIM: begin
        if (!rel_req_i) state_d = ST_TURN;
      end
      ST_TURN: begin
        if (turn_done_i) state_d = want_rfsh_i ? ST_RFSH : ST_OWN;
      end
      default: state_d = ST_OWN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_OWN;
    else     state_q <= state_d;
  end

  always_comb begin
    grant_start_o = (state_d == ST_RFSH) && (state_q != ST_RFSH);
    in_turn_o     = (state_q == ST_TURN);
    rel_ack_o     = (state_q == ST_REL);
    rfsh_gnt_o    = (state_q == ST_RFSH);
    local_drive_o = local_drives(state_q);
  end

endmodule

// File: rtl/bus_release_arbiter.sv
module bus_release_arbiter #(
  parameter int TURN_CYCLES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic rel_req_i,
  input  logic rfsh_req_i,
  input  logic cyc_end_i,
  input  logic lock_i,
  input  logic rfsh_done_i,
  output logic rel_ack_o,
  output logic rfsh_gnt_o,
  output logic local_drive_o
);
  // Named internal events, visible to the bound checker.
  logic boundary;
  logic want_rfsh;
  logic grant_start;
  logic in_turn;
  logic turn_done;

  bra_boundary u_bnd (
    .cyc_end_i (cyc_end_i),
    .lock_i    (lock_i),
    .boundary_o(boundary)
  );

  bra_rfsh_pend u_pend (
    .clk          (clk),
    .rst          (rst),
    .rfsh_req_i   (rfsh_req_i),
    .grant_start_i(grant_start),
    .want_o       (want_rfsh)
  );

  bra_turn_timer #(.TURN_CYCLES(TURN_CYCLES)) u_turn (
    .clk        (clk),
    .rst        (rst),
    .in_turn_i  (in_turn),
    .turn_done_o(turn_done)
  );

  bra_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .boundary_i   (boundary),
    .rel_req_i    (rel_req_i),
    .want_rfsh_i  (want_rfsh),
    .rfsh_done_i  (rfsh_done_i),
    .turn_done_i  (turn_done),
    .grant_start_o(grant_start),
    .in_turn_o    (in_turn),
    .rel_ack_o    (rel_ack_o),
    .rfsh_gnt_o   (rfsh_gnt_o),
    .local_drive_o(local_drive_o)
  );

endmodule

// File: rtl/bra_checker.sv
module bra_checker (
  input logic clk,
  input logic rst,
  input logic rel_req_i,
  input logic rfsh_done_i,
  input logic boundary,
  input logic rel_ack_o,
  input logic rfsh_gnt_o,
  input logic local_drive_o
);

  // R8: never lend the bus and refresh at once
  p_ack_gnt_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(rel_ack_o && rfsh_gnt_o));

  // R2: while lent out, the local side is off the bus
  p_ack_no_drive_r2: assert property (@(posedge clk) disable iff (rst)
    rel_ack_o |-> !local_drive_o);

  // R2: acknowledge only rises after a request at a boundary or refresh end
  p_ack_rise_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(rel_ack_o) |-> $past(rel_req_i && (boundary || rfsh_done_i)));

  // R3 / R4: without a qualified boundary an idle owner does not lend
  p_no_boundary_r4: assert property (@(posedge clk) disable iff (rst)
    (!rel_ack_o && !rfsh_gnt_o && !boundary) |=> !rel_ack_o);

  // R5: a withdrawn request drops the acknowledge next cycle
  p_ack_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (rel_ack_o && !rel_req_i) |=> !rel_ack_o);

  // R5: local side waits a turnaround after the acknowledge falls
  p_turnaround_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(rel_ack_o) |-> !local_drive_o);

  // R6: grant holds until the refresh completes
  p_gnt_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (rfsh_gnt_o && !rfsh_done_i) |=> rfsh_gnt_o);

  // R6: local side keeps the bus during refresh
  p_gnt_drive_r6: assert property (@(posedge clk) disable iff (rst)
    rfsh_gnt_o |-> local_drive_o);

endmodule

bind bus_release_arbiter bra_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .rel_req_i    (rel_req_i),
  .rfsh_done_i  (rfsh_done_i),
  .boundary     (boundary),
  .rel_ack_o    (rel_ack_o),
  .rfsh_gnt_o   (rfsh_gnt_o),
  .local_drive_o(local_drive_o)
);

// File: tb/sim_bus_release_arbiter.sv
`timescale 1ns/1ps
module sim_bus_release_arbiter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rel_req = 1'b0, rfsh_req = 1'b0, cyc_end = 1'b0, lock = 1'b0, rfsh_done = 1'b0;
  logic rel_ack, rfsh_gnt, local_drive;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  bus_release_arbiter u0 (
    .clk(clk), .rst(rst), .rel_req_i(rel_req), .rfsh_req_i(rfsh_req),
    .cyc_end_i(cyc_end), .lock_i(lock), .rfsh_done_i(rfsh_done),
    .rel_ack_o(rel_ack), .rfsh_gnt_o(rfsh_gnt), .local_drive_o(local_drive)
  );

  // Driver: set inputs for the coming edge and push what the outputs
  // must show after it: {ack, gnt, drive}.
  task automatic step(input logic r, input logic f, input logic e,
                      input logic l, input logic d,
                      input logic ea, input logic eg, input logic ed,
                      input string tag);
    @(negedge clk);
    rel_req = r; rfsh_req = f; cyc_end = e; lock = l; rfsh_done = d;
    exp_q.push_back({ea, eg, ed});
    tag_q.push_back(tag);
  endtask

  // Monitor: compare shortly after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({rel_ack, rfsh_gnt, local_drive} !== e) begin
          fails++;
          $display("FAIL %s: {ack,gnt,drive} got %b expected %b", t,
                   {rel_ack, rfsh_gnt, local_drive}, e);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    //    req rf end lk dn  ack gnt drv
    step(0, 0, 0, 0, 0,  0, 0, 1, "R1 reset");
    step(0, 0, 1, 0, 0,  0, 0, 1, "R1 reset");
    @(negedge clk); rst = 1'b0;
    exp_q.push_back(3'b001); tag_q.push_back("R1 idle after reset");
    step(0, 0, 1, 0, 0,  0, 0, 1, "R1 boundary with nothing pending");
    // R4: request without strobe
    step(1, 0, 0, 0, 0,  0, 0, 1, "R4 no strobe");
    step(1, 0, 0, 0, 0,  0, 0, 1, "R4 no strobe");
    // R3: strobe under lock
    step(1, 0, 1, 1, 0,  0, 0, 1, "R3 locked strobe");
    step(1, 0, 0, 1, 0,  0, 0, 1, "R3 still locked");
    // R2: qualified boundary
    step(1, 0, 1, 0, 0,  1, 0, 0, "R2 release");
    step(1, 0, 0, 0, 0,  1, 0, 0, "R2 held");
    // R5 / R9: drop, re-raise during turnaround
    step(0, 0, 0, 0, 0,  0, 0, 0, "R5 ack drop, turnaround");
    step(1, 0, 0, 0, 0,  0, 0, 1, "R5 drive resumes");
    step(1, 0, 0, 0, 0,  0, 0, 1, "R9 re-raised request not carried");
    step(1, 0, 1, 0, 0,  1, 0, 0, "R9 fresh boundary acknowledges");
    step(0, 0, 0, 0, 0,  0, 0, 0, "R5 turnaround");
    step(0, 0, 0, 0, 0,  0, 0, 1, "R5 owner again");
    // R6: pulse remembered until boundary
    step(0, 1, 0, 0, 0,  0, 0, 1, "R6 pulse, no strobe");
    step(0, 0, 0, 0, 0,  0, 0, 1, "R6 pending");
    step(0, 0, 1, 1, 0,  0, 0, 1, "R3 locked strobe defers refresh");
    step(0, 0, 1, 0, 0,  0, 1, 1, "R6 grant");
    step(0, 0, 0, 0, 0,  0, 1, 1, "R6 grant held");
    step(0, 0, 0, 0, 1,  0, 0, 1, "R6 done");
    step(0, 0, 1, 0, 0,  0, 0, 1, "R6 request consumed");
    // R7: both at one boundary
    step(1, 1, 1, 0, 0,  0, 1, 1, "R7 refresh first");
    step(1, 0, 0, 0, 0,  0, 1, 1, "R7 release waits");
    step(1, 0, 0, 0, 1,  1, 0, 0, "R7 release after refresh");
    step(0, 0, 0, 0, 0,  0, 0, 0, "R7 turnaround");
    step(0, 0, 0, 0, 0,  0, 0, 1, "R7 owner");
    // R10: request during active grant
    step(0, 1, 1, 0, 0,  0, 1, 1, "R10 first grant");
    step(0, 1, 0, 0, 0,  0, 1, 1, "R10 new request during grant");
    step(0, 0, 0, 0, 1,  0, 0, 1, "R10 first done");
    step(0, 0, 1, 0, 0,  0, 1, 1, "R10 second grant");
    step(0, 0, 0, 0, 1,  0, 0, 1, "R10 second done");
    // R8: reclaim while released
    step(1, 0, 1, 0, 0,  1, 0, 0, "R8 released");
    step(1, 1, 0, 0, 0,  0, 0, 0, "R8 ack dropped to reclaim");
    step(1, 0, 0, 0, 0,  0, 0, 0, "R8 waiting for request drop");
    step(0, 0, 0, 0, 0,  0, 0, 0, "R8 turnaround");
    step(0, 0, 0, 0, 0,  0, 1, 1, "R8 refresh after reclaim");
    step(0, 0, 0, 0, 1,  0, 0, 1, "R8 refresh done");
    step(0, 0, 0, 0, 0,  0, 0, 1, "R1 idle end");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule